// File: doc/BRIEF.md
# Accumulator Scratchpad Column Allocator

This block owns the bookkeeping for a result scratchpad of 128 lanes by 512 columns of 32-bit words (256 KB). A requester asks for a column count and, once space exists, receives an opaque 32-bit handle naming a lane/column coordinate. Every grant covers whole columns across all 128 lanes, so a grant of 256 columns is exactly one 128 x 256 tile of 32-bit results, and two such tiles fit side by side. Columns stay reserved until the requester hands the same handle and the same size back. A request that does not fit is parked, never split, and is granted once a release makes room.

Free space is tracked as a 16-bit mask of 32-column chunks. A grant is always aligned to its own size and takes the lowest free range of that alignment, in one cycle. A lane-parallel read port takes a granted handle and a column offset, presents the column to the storage array, and one cycle later passes each lane's word of that column to the readers (reader L gets lane L). The storage array itself and the engine that fills it sit outside the block.

Top module: `accum_col_alloc`

## Requirements
- R1: After reset no column is reserved, all pulse and busy outputs are 0, `rd_data` is 0, and a first 512-column request is granted at column 0.
- R2: A request whose `req_cols` is not one of 32, 64, 128, 256 or 512 raises `req_err` for one cycle in the next cycle, produces no grant and reserves nothing.
- R3: A request that fits is answered in the next cycle by a one-cycle `gnt_valid` with `gnt_handle` bits [31:16] = 0 (lane) and bits [15:0] = the start column, a multiple of the request size.
- R4: The granted range is the lowest size-aligned range whose columns are all free; it never overlaps a reserved column.
- R5: A legal request that does not fit sets `req_busy` and is held; it is granted in the cycle after the one in which a release frees enough room, and `req_busy` then clears. A request arriving while `req_busy` is 1 raises `req_err` and is dropped.
- R6: A release whose handle and `rel_cols` match a live grant exactly returns those columns to the free pool with no `rel_err`.
- R7: A release with a nonzero lane field, an unaligned or out-of-range column, an illegal size, a size differing from the grant, or a column that is not the start of a live grant raises `rel_err` the next cycle and leaves every reservation unchanged.
- R8: Two 256-column requests on an empty pool are granted at columns 0 and 256; both tiles are held at once.
- R9: A read with a live handle and an offset below its size drives `sp_rd_en` = 1 and `sp_col` = start + offset in the same cycle; in the next cycle `rd_out_valid` = 1 and word L of `rd_data` (bits [32L+31:32L]) equals word L of `sp_rdata`.
- R10: A read whose offset reaches the grant size, whose handle is not the start of a live grant, or whose lane field is nonzero keeps `sp_rd_en` at 0 and raises `rd_out_err` the next cycle with `rd_data` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle allocation request |
| req_cols | input | 10 | Columns asked for |
| req_busy | output | 1 | A request is parked waiting for room |
| req_err | output | 1 | Illegal size, or request while busy |
| gnt_valid | output | 1 | Grant pulse |
| gnt_handle | output | 32 | Granted handle: lane [31:16], start column [15:0] |
| rel_valid | input | 1 | One-cycle release |
| rel_handle | input | 32 | Handle being returned |
| rel_cols | input | 10 | Size being returned |
| rel_err | output | 1 | Release rejected |
| rd_valid | input | 1 | One-cycle read request |
| rd_handle | input | 32 | Handle of the region to read |
| rd_offset | input | 10 | Column offset inside the region |
| sp_rd_en | output | 1 | Read strobe to the storage array |
| sp_col | output | 9 | Column presented to the storage array |
| sp_rdata | input | 4096 | All lane words of that column, one cycle after the strobe |
| rd_out_valid | output | 1 | Lane-parallel read result is valid |
| rd_out_err | output | 1 | Read rejected |
| rd_data | output | 4096 | Word of each lane, lane L in bits [32L+31:32L] |

## Verification
A wrong free mask or a lost ownership record never shows directly; it surfaces at the next grant as a start column that is not the lowest aligned free one, as a request parking when the pool has room, or as a correct release being rejected. A corrupt size record shows on the next read near a region's upper edge as an error where data was due, or the reverse. Because every grant and release is visible one cycle later, the bench keeps its own chunk map and compares each handle and each error pulse in the cycle it appears, so a fault is reported at the first operation that depends on the damaged state.

// File: rtl/ascp_pkg.sv
package ascp_pkg;
  localparam int HANDLE_W = 32;

  typedef struct packed {
    logic [15:0] lane;
    logic [15:0] col;
  } acc_handle_t;
endpackage

// File: rtl/ascp_size_decode.sv
// Maps a column count to a size code; legal only for CHUNK_COLS << code.
module ascp_size_decode #(
  parameter int CHUNK_COLS = 32,
  parameter int NSIZE      = 5,
  parameter int CW         = 10,
  parameter int SZW        = 3
) (
  input  logic [CW-1:0]  cols,
  output logic           legal,
  output logic [SZW-1:0] code
);
  always_comb begin
    legal = 1'b0;
    code  = '0;
    for (int s = 0; s < NSIZE; s++) begin
      if (cols == CW'(CHUNK_COLS << s)) begin
        legal = 1'b1;
        code  = SZW'(s);
      end
    end
  end
endmodule

// File: rtl/ascp_chunk_search.sv
// Lowest size-aligned free slot for every size, then pick by code.
module ascp_chunk_search #(
  parameter int NCHUNK = 16,
  parameter int NSIZE  = 5,
  parameter int CIDX_W = 4,
  parameter int SZW    = 3
) (
  input  logic [NCHUNK-1:0] used,
  input  logic [SZW-1:0]    code,
  output logic              found,
  output logic [CIDX_W-1:0] start
);
  logic [NSIZE-1:0]  f_all;
  logic [CIDX_W-1:0] st_all [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int N     = 1 << s;
    localparam int SLOTS = NCHUNK / N;
    logic [SLOTS-1:0]  fr;
    logic              fnd;
    logic [CIDX_W-1:0] st;

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      assign fr[j] = ~|used[j*N +: N];
    end

    always_comb begin
      fnd = 1'b0;
      st  = '0;
      for (int j = SLOTS - 1; j >= 0; j--) begin
        if (fr[j]) begin
          fnd = 1'b1;
          st  = CIDX_W'(j * N);
        end
      end
    end

    assign f_all[s]  = fnd;
    assign st_all[s] = st;
  end

  assign found = f_all[code];
  assign start = st_all[code];
endmodule

// File: rtl/ascp_owner_table.sv
// Per-chunk record of which chunks start a live grant and its size code.
module ascp_owner_table #(
  parameter int NCHUNK = 16,
  parameter int CIDX_W = 4,
  parameter int SZW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [CIDX_W-1:0] set_idx,
  input  logic [SZW-1:0]    set_code,
  input  logic              clr_en,
  input  logic [CIDX_W-1:0] rel_idx,
  input  logic [SZW-1:0]    rel_code,
  output logic              rel_match,
  input  logic [CIDX_W-1:0] rd_idx,
  output logic              rd_head,
  output logic [SZW-1:0]    rd_code
);
  logic [NCHUNK-1:0] head_q, head_d;
  logic [SZW-1:0]    code_q [NCHUNK];

  always_comb begin
    head_d = head_q;
    if (clr_en) head_d[rel_idx] = 1'b0;
    if (set_en) head_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      for (int c = 0; c < NCHUNK; c++) code_q[c] <= '0;
    end else begin
      head_q <= head_d;
      if (set_en) code_q[set_idx] <= set_code;
    end
  end

  assign rel_match = head_q[rel_idx] & (code_q[rel_idx] == rel_code);
  assign rd_head   = head_q[rd_idx];
  assign rd_code   = code_q[rd_idx];
endmodule

// File: rtl/ascp_read_gate.sv
// Validates a read against the owner table and forwards lane words.
module ascp_read_gate import ascp_pkg::*; #(
  parameter int LANES      = 128,
  parameter int WORD_W     = 32,
  parameter int COLS       = 512,
  parameter int CHUNK_COLS = 32,
  parameter int CW         = 10,
  parameter int COLW       = 9,
  parameter int CIDX_W     = 4,
  parameter int SZW        = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_valid,
  input  logic [HANDLE_W-1:0]     rd_handle,
  input  logic [CW-1:0]           rd_offset,
  output logic [CIDX_W-1:0]       q_idx,
  input  logic                    q_head,
  input  logic [SZW-1:0]          q_code,
  output logic                    sp_rd_en,
  output logic [COLW-1:0]         sp_col,
  input  logic [LANES*WORD_W-1:0] sp_rdata,
  output logic                    rd_out_valid,
  output logic                    rd_out_err,
  output logic [LANES*WORD_W-1:0] rd_data
);
  localparam int CSH = $clog2(CHUNK_COLS);

  acc_handle_t     h;
  logic [CW-1:0]   span;
  logic            ok;
  logic            good_q, bad_q;

  assign h     = acc_handle_t'(rd_handle);
  assign q_idx = h.col[CSH +: CIDX_W];
  assign span  = CW'(CHUNK_COLS) << q_code;
  assign ok    = rd_valid & (h.lane == '0) & (h.col[CSH-1:0] == '0) &
                 (h.col[15:COLW] == '0) & q_head & (rd_offset < span);

  assign sp_rd_en = ok;
  assign sp_col   = h.col[COLW-1:0] + rd_offset[COLW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      good_q <= ok;
      bad_q  <= rd_valid & ~ok;
    end
  end

  assign rd_out_valid = good_q;
  assign rd_out_err   = bad_q;
  assign rd_data      = good_q ? sp_rdata : '0;
endmodule

// File: rtl/accum_col_alloc.sv
module accum_col_alloc import ascp_pkg::*; #(
  parameter int LANES      = 128,
  parameter int COLS       = 512,
  parameter int WORD_W     = 32,
  parameter int CHUNK_COLS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [$clog2(COLS):0]      req_cols,
  output logic                       req_busy,
  output logic                       req_err,
  output logic                       gnt_valid,
  output logic [HANDLE_W-1:0]        gnt_handle,
  input  logic                       rel_valid,
  input  logic [HANDLE_W-1:0]        rel_handle,
  input  logic [$clog2(COLS):0]      rel_cols,
  output logic                       rel_err,
  input  logic                       rd_valid,
  input  logic [HANDLE_W-1:0]        rd_handle,
  input  logic [$clog2(COLS):0]      rd_offset,
  output logic                       sp_rd_en,
  output logic [$clog2(COLS)-1:0]    sp_col,
  input  logic [LANES*WORD_W-1:0]    sp_rdata,
  output logic                       rd_out_valid,
  output logic                       rd_out_err,
  output logic [LANES*WORD_W-1:0]    rd_data
);
  localparam int NCHUNK = COLS / CHUNK_COLS;
  localparam int NSIZE  = $clog2(NCHUNK) + 1;
  localparam int CW     = $clog2(COLS) + 1;
  localparam int COLW   = $clog2(COLS);
  localparam int CIDX_W = $clog2(NCHUNK);
  localparam int SZW    = $clog2(NSIZE);
  localparam int CSH    = $clog2(CHUNK_COLS);

  // reset: asserted asynchronously, released on the clock
  logic rs_meta, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_s_n <= rs_meta;
    end
  end

  function automatic logic [NCHUNK-1:0] span_mask(input logic [CIDX_W-1:0] base,
                                                  input logic [SZW-1:0]    code);
    for (int c = 0; c < NCHUNK; c++)
      span_mask[c] = (c >= int'(base)) && (c < int'(base) + (1 << code));
  endfunction

  // size decoders
  logic           req_legal, rel_legal;
  logic [SZW-1:0] req_code, rel_code;

  ascp_size_decode #(.CHUNK_COLS(CHUNK_COLS), .NSIZE(NSIZE), .CW(CW), .SZW(SZW))
    u_req_dec (.cols(req_cols), .legal(req_legal), .code(req_code));
  ascp_size_decode #(.CHUNK_COLS(CHUNK_COLS), .NSIZE(NSIZE), .CW(CW), .SZW(SZW))
    u_rel_dec (.cols(rel_cols), .legal(rel_legal), .code(rel_code));

  // state
  logic [NCHUNK-1:0] used_q, used_d;
  logic              pend_q, pend_d;
  logic [SZW-1:0]    pend_code_q;
  logic              pend_code_en;
  logic              req_err_q, req_err_d;
  logic              gnt_valid_q, gnt_valid_d;
  acc_handle_t       gnt_handle_q, gnt_handle_d;
  logic              rel_err_q, rel_err_d;

  // request path
  logic              new_req, srch_active, srch_found, do_grant;
  logic [SZW-1:0]    srch_code;
  logic [CIDX_W-1:0] srch_start;

  assign new_req     = req_valid & req_legal & ~pend_q;
  assign srch_active = pend_q | new_req;
  assign srch_code   = pend_q ? pend_code_q : req_code;

  ascp_chunk_search #(.NCHUNK(NCHUNK), .NSIZE(NSIZE), .CIDX_W(CIDX_W), .SZW(SZW))
    u_search (.used(used_q), .code(srch_code), .found(srch_found), .start(srch_start));

  assign do_grant = srch_active & srch_found;

  // release path
  acc_handle_t       rel_h;
  logic [CIDX_W-1:0] rel_idx, rel_amask;
  logic              rel_shape_ok, rel_match, rel_ok;

  assign rel_h        = acc_handle_t'(rel_handle);
  assign rel_idx      = rel_h.col[CSH +: CIDX_W];
  assign rel_amask    = CIDX_W'((32'd1 << rel_code) - 32'd1);
  assign rel_shape_ok = rel_valid & rel_legal & (rel_h.lane == '0) &
                        (rel_h.col[CSH-1:0] == '0) & (rel_h.col[15:COLW] == '0) &
                        ((rel_idx & rel_amask) == '0);
  assign rel_ok       = rel_shape_ok & rel_match;

  // read path
  logic [CIDX_W-1:0] rd_q_idx;
  logic              rd_q_head;
  logic [SZW-1:0]    rd_q_code;

  ascp_owner_table #(.NCHUNK(NCHUNK), .CIDX_W(CIDX_W), .SZW(SZW)) u_owner (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .set_en   (do_grant),
    .set_idx  (srch_start),
    .set_code (srch_code),
    .clr_en   (rel_ok),
    .rel_idx  (rel_idx),
    .rel_code (rel_code),
    .rel_match(rel_match),
    .rd_idx   (rd_q_idx),
    .rd_head  (rd_q_head),
    .rd_code  (rd_q_code)
  );

  ascp_read_gate #(
    .LANES(LANES), .WORD_W(WORD_W), .COLS(COLS), .CHUNK_COLS(CHUNK_COLS),
    .CW(CW), .COLW(COLW), .CIDX_W(CIDX_W), .SZW(SZW)
  ) u_read (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .rd_valid    (rd_valid),
    .rd_handle   (rd_handle),
    .rd_offset   (rd_offset),
    .q_idx       (rd_q_idx),
    .q_head      (rd_q_head),
    .q_code      (rd_q_code),
    .sp_rd_en    (sp_rd_en),
    .sp_col      (sp_col),
    .sp_rdata    (sp_rdata),
    .rd_out_valid(rd_out_valid),
    .rd_out_err  (rd_out_err),
    .rd_data     (rd_data)
  );

  // next state; the search looks at the map before this cycle's release
  always_comb begin
    logic [NCHUNK-1:0] rel_mask, gnt_mask;
    rel_mask          = rel_ok   ? span_mask(rel_idx, rel_code)      : '0;
    gnt_mask          = do_grant ? span_mask(srch_start, srch_code)  : '0;
    used_d            = (used_q & ~rel_mask) | gnt_mask;
    pend_d            = srch_active & ~srch_found;
    pend_code_en      = new_req;
    req_err_d         = req_valid & (~req_legal | pend_q);
    rel_err_d         = rel_valid & ~rel_ok;
    gnt_valid_d       = do_grant;
    gnt_handle_d.lane = '0;
    gnt_handle_d.col  = 16'(srch_start) << CSH;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      used_q       <= '0;
      pend_q       <= 1'b0;
      pend_code_q  <= '0;
      req_err_q    <= 1'b0;
      gnt_valid_q  <= 1'b0;
      gnt_handle_q <= '0;
      rel_err_q    <= 1'b0;
    end else begin
      used_q      <= used_d;
      pend_q      <= pend_d;
      req_err_q   <= req_err_d;
      gnt_valid_q <= gnt_valid_d;
      rel_err_q   <= rel_err_d;
      if (pend_code_en) pend_code_q  <= req_code;
      if (do_grant)     gnt_handle_q <= gnt_handle_d;
    end
  end

  assign req_busy   = pend_q;
  assign req_err    = req_err_q;
  assign gnt_valid  = gnt_valid_q;
  assign gnt_handle = gnt_handle_q;
  assign rel_err    = rel_err_q;
endmodule

// File: rtl/accum_col_alloc_chk.sv
module accum_col_alloc_chk #(
  parameter int LANES      = 128,
  parameter int WORD_W     = 32,
  parameter int COLS       = 512,
  parameter int CHUNK_COLS = 32
) (
  input logic                          clk,
  input logic                          rst_s_n,
  input logic [COLS/CHUNK_COLS-1:0]    used_q,
  input logic                          gnt_valid,
  input logic [31:0]                   gnt_handle,
  input logic                          rel_err,
  input logic                          req_busy,
  input logic                          rd_out_valid,
  input logic                          rd_out_err,
  input logic [LANES*WORD_W-1:0]       rd_data
);
  localparam int CSH    = $clog2(CHUNK_COLS);
  localparam int CIDX_W = $clog2(COLS / CHUNK_COLS);

  logic [CIDX_W-1:0] gidx;
  assign gidx = gnt_handle[CSH +: CIDX_W];

  // R3: lane field zero and chunk-aligned start on every grant
  p_grant_shape_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    gnt_valid |-> (gnt_handle[31:16] == 16'd0) && (gnt_handle[CSH-1:0] == '0));

  // R4: the granted start chunk was free before and is reserved now
  p_grant_free_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    gnt_valid |-> ((($past(used_q) >> gidx) & 1) == 0) && used_q[gidx]);

  // R6: reservations only appear together with a grant
  p_map_grows_on_grant_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !gnt_valid |-> ((used_q & ~$past(used_q)) == '0));

  // R7: a rejected release leaves the map alone
  p_bad_release_keeps_map_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rel_err && !gnt_valid) |-> (used_q == $past(used_q)));

  // R5: a grant never coexists with a parked request
  p_grant_clears_busy_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    gnt_valid |-> !req_busy);

  // R10: rejected reads return zeros and no valid
  p_read_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_out_err |-> (!rd_out_valid && (rd_data == '0)));
endmodule

bind accum_col_alloc accum_col_alloc_chk #(
  .LANES(LANES), .WORD_W(WORD_W), .COLS(COLS), .CHUNK_COLS(CHUNK_COLS)
) u_chk (
  .clk         (clk),
  .rst_s_n     (rst_s_n),
  .used_q      (used_q),
  .gnt_valid   (gnt_valid),
  .gnt_handle  (gnt_handle),
  .rel_err     (rel_err),
  .req_busy    (req_busy),
  .rd_out_valid(rd_out_valid),
  .rd_out_err  (rd_out_err),
  .rd_data     (rd_data)
);

// File: tb/tb_accum_col_alloc.sv
`timescale 1ns/1ps
module tb_accum_col_alloc;
  localparam int LN = 128;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req_valid;
  logic [9:0]     req_cols;
  logic           req_busy, req_err, gnt_valid;
  logic [31:0]    gnt_handle;
  logic           rel_valid;
  logic [31:0]    rel_handle;
  logic [9:0]     rel_cols;
  logic           rel_err;
  logic           rd_valid;
  logic [31:0]    rd_handle;
  logic [9:0]     rd_offset;
  logic           sp_rd_en;
  logic [8:0]     sp_col;
  logic [LN*32-1:0] sp_rdata;
  logic           rd_out_valid, rd_out_err;
  logic [LN*32-1:0] rd_data;

  always #2.5 clk = ~clk;

  accum_col_alloc dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_cols(req_cols), .req_busy(req_busy), .req_err(req_err),
    .gnt_valid(gnt_valid), .gnt_handle(gnt_handle),
    .rel_valid(rel_valid), .rel_handle(rel_handle), .rel_cols(rel_cols), .rel_err(rel_err),
    .rd_valid(rd_valid), .rd_handle(rd_handle), .rd_offset(rd_offset),
    .sp_rd_en(sp_rd_en), .sp_col(sp_col), .sp_rdata(sp_rdata),
    .rd_out_valid(rd_out_valid), .rd_out_err(rd_out_err), .rd_data(rd_data)
  );

  // storage array model: lane L of column c holds {L, c}
  always_ff @(posedge clk)
    if (sp_rd_en)
      for (int l = 0; l < LN; l++) sp_rdata[l*32 +: 32] <= {16'(l), 7'd0, sp_col};

  int checks = 0;
  int errors = 0;
  bit [15:0] m_used;
  int        m_head [16];

  task automatic check(bit ok, string rq, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic bit legal_size(int c);
    return c == 32 || c == 64 || c == 128 || c == 256 || c == 512;
  endfunction

  function automatic int find_slot(int n);
    for (int j = 0; j < 16; j += n) begin
      bit fr = 1'b1;
      for (int k = 0; k < n; k++) if (m_used[j+k]) fr = 1'b0;
      if (fr) return j;
    end
    return -1;
  endfunction

  task automatic mark(int idx, int n);
    m_head[idx] = n;
    for (int k = 0; k < n; k++) m_used[idx+k] = 1'b1;
  endtask

  task automatic do_request(int cols, string rq);
    bit lg = legal_size(cols);
    int st = lg ? find_slot(cols / 32) : -1;
    req_valid = 1'b1; req_cols = 10'(cols);
    @(negedge clk);
    req_valid = 1'b0;
    if (!lg)
      check(req_err === 1'b1 && gnt_valid === 1'b0, rq, {req_err, gnt_valid}, 2'b10);
    else if (st >= 0) begin
      check(gnt_valid === 1'b1 && gnt_handle === 32'(st * 32), rq, gnt_handle, st * 32);
      mark(st, cols / 32);
    end else
      check(req_busy === 1'b1 && gnt_valid === 1'b0, rq, {req_busy, gnt_valid}, 2'b10);
  endtask

  task automatic do_release(int col, int cols, int lane, string rq);
    bit lg = legal_size(cols);
    int n  = lg ? cols / 32 : 1;
    bit ok = lg && lane == 0 && col % 32 == 0 && col < 512;
    if (ok) ok = ((col / 32) % n == 0) && m_head[col/32] == n;
    rel_valid = 1'b1; rel_handle = {16'(lane), 16'(col)}; rel_cols = 10'(cols);
    @(negedge clk);
    rel_valid = 1'b0;
    check(rel_err === !ok, rq, rel_err, !ok);
    if (ok) begin
      m_head[col/32] = 0;
      for (int k = 0; k < n; k++) m_used[col/32 + k] = 1'b0;
    end
  endtask

  task automatic do_read(int col, int off, int lane, string rq);
    bit ok = lane == 0 && col % 32 == 0 && col < 512;
    int mism = 0;
    if (ok) ok = m_head[col/32] > 0 && off < m_head[col/32] * 32;
    rd_valid = 1'b1; rd_handle = {16'(lane), 16'(col)}; rd_offset = 10'(off);
    #1;
    check(sp_rd_en === ok && (!ok || sp_col === 9'(col + off)), rq, {sp_rd_en, sp_col},
          {ok, 9'(col + off)});
    @(negedge clk);
    rd_valid = 1'b0;
    if (ok) begin
      for (int l = 0; l < LN; l++)
        if (rd_data[l*32 +: 32] !== {16'(l), 7'd0, 9'(col + off)}) mism++;
      check(rd_out_valid === 1'b1 && rd_out_err === 1'b0 && mism == 0, rq, mism, 0);
    end else
      check(rd_out_err === 1'b1 && rd_out_valid === 1'b0 && rd_data === '0, rq,
            {rd_out_err, rd_out_valid}, 2'b10);
  endtask

  function automatic int pick_live();
    int s = int'($urandom % 16);
    for (int k = 0; k < 16; k++) if (m_head[(s + k) % 16] > 0) return (s + k) % 16;
    return -1;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd20511));
    m_used = '0;
    for (int i = 0; i < 16; i++) m_head[i] = 0;
    rst_n = 1'b0; req_valid = 0; req_cols = 0; rel_valid = 0; rel_handle = 0;
    rel_cols = 0; rd_valid = 0; rd_handle = 0; rd_offset = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(gnt_valid === 0 && req_busy === 0 && req_err === 0 && rel_err === 0 &&
          rd_out_valid === 0 && rd_out_err === 0 && rd_data === '0, "R1 reset", 0, 0);
    do_request(512, "R1 first full grant");

    // R5 park, reject while busy, grant after release
    do_request(32, "R5 park");
    req_valid = 1'b1; req_cols = 10'd64;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_err === 1 && req_busy === 1 && gnt_valid === 0, "R5 request while busy",
          {req_err, req_busy, gnt_valid}, 3'b110);
    do_release(0, 512, 0, "R6 release full");
    check(gnt_valid === 0, "R5 no grant in release cycle", gnt_valid, 0);
    @(negedge clk);
    check(gnt_valid === 1 && gnt_handle === 32'd0 && req_busy === 0, "R5 late grant",
          gnt_handle, 0);
    mark(0, 1);
    do_release(0, 32, 0, "R6 release small");

    // R2 illegal sizes
    do_request(48, "R2 size 48");
    do_request(0, "R2 size 0");
    do_request(1023, "R2 size 1023");
    do_request(96, "R2 size 96");

    // R7 wrong-size release keeps the pool full
    do_request(512, "R3 full");
    do_release(0, 256, 0, "R7 size mismatch");
    do_request(32, "R7 pool still full");
    do_release(0, 512, 0, "R6 release full again");
    @(negedge clk);
    check(gnt_valid === 1 && gnt_handle === 32'd0, "R5 grant after room", gnt_handle, 0);
    mark(0, 1);
    do_release(0, 32, 0, "R6 tidy");

    // R8 two half tiles
    do_request(256, "R8 first half");
    do_request(256, "R8 second half");
    do_release(0, 256, 0, "R6 half");
    do_release(256, 256, 0, "R6 half");

    // R4 lowest aligned placement and R7 malformed releases
    do_request(32, "R4 chunk0");
    do_request(64, "R4 aligned 64");
    do_request(32, "R4 fill gap");
    do_release(32, 64, 0, "R7 not a head");
    do_release(16, 32, 0, "R7 unaligned");
    do_release(64, 64, 3, "R7 lane field");
    do_release(256, 32, 0, "R7 not allocated");
    do_release(64, 48, 0, "R7 illegal size");
    do_request(32, "R7 map unchanged");

    // R9 / R10 reads
    do_request(128, "R3 read region");
    do_read(256, 0, 0, "R9 first column");
    do_read(256, 127, 0, "R9 last column");
    do_read(256, 128, 0, "R10 past end");
    do_read(288, 0, 0, "R10 inside not head");
    do_read(256, 5, 1, "R10 lane field");
    do_read(448, 0, 0, "R10 free region");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int r = int'($urandom % 10);
      if (r <= 4) begin
        int cols = 32 << ($urandom % 5);
        if (find_slot(cols / 32) >= 0) do_request(cols, "R3 random grant");
        else begin
          int h = pick_live();
          if (h >= 0) do_release(h * 32, m_head[h] * 32, 0, "R6 random release");
        end
      end else if (r == 5) begin
        do_request(int'($urandom % 31) * 32 + 1 + int'($urandom % 31), "R2 random illegal");
      end else if (r <= 7) begin
        int h = pick_live();
        if (h >= 0) do_release(h * 32, m_head[h] * 32, 0, "R6 random release");
      end else if (r == 8) begin
        int h = pick_live();
        if (h >= 0) do_release(h * 32, (m_head[h] == 16 ? 8 : m_head[h] * 2) * 32, 0,
                               "R7 random bad size");
      end else begin
        int h = pick_live();
        if (h >= 0) do_read(h * 32, int'($urandom % 512), 0, "R9 random read");
      end
    end

    for (int i = 0; i < 16; i++)
      if (m_head[i] > 0) do_release(i * 32, m_head[i] * 32, 0, "R6 drain");
    do_request(512, "R6 pool empty again");
    summary();
  end
endmodule